// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits beside the fetch stage of a processor pipeline. For every fetch address it answers in the same cycle: is this address a known branch, should it be predicted taken, and where does it go. Entries are found by a cache-like search. Low address bits select a set. The remaining address bits are compared against a stored tag in each way of that set. Every way keeps a valid flag, the tag, the full branch target and a 2-bit saturating direction counter. A fetch address that matches no entry gets the fallback prediction "not taken".

Once a branch has been resolved later in the pipeline, its address, its real direction and its real target come back on the update port. If the branch already has an entry, the counter moves one step toward the outcome and the target is rewritten. If it has no entry and was taken, it replaces the least recently used way of its set. If it has no entry and was not taken, it is dropped. Replacement age is an exact ordering of the ways within each set. The address inputs are word (instruction) addresses, so every address bit takes part in either the index or the tag.

Top module: `btb_assoc`

## Requirements
- R1: After reset is released, every lookup misses (`lk_hit`=0), because reset clears all valid flags.
- R2: A lookup that misses, or one with `lk_valid`=0, reports `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R3: An update with `up_taken`=0 for an address that has no entry creates no entry.
- R4: An update with `up_taken`=1 for an address that has no entry allocates one. From the next cycle, a lookup of that address hits, predicts taken and returns the recorded target.
- R5: Counter encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. Allocation writes 10. Each hitting update moves the counter one step toward the outcome and saturates at 00 and 11. `lk_taken` is bit 1 of the counter, so from a strong state two opposite outcomes are needed to flip the prediction.
- R6: An update that hits overwrites the stored target with `up_target`, whatever the outcome.
- R7: With the default of 256 entries in 4 ways, the set index is `pc[5:0]` and the tag is `pc[31:6]`. Four branches with the same index coexist, and at most one way matches any lookup.
- R8: Allocation replaces the least recently used way of the set. Every lookup hit and every allocation makes the touched way the most recent. Update hits leave the ordering unchanged.
- R9: The lookup result is combinational from the stored state. An update becomes visible to lookups from the cycle after its clock edge.
- R10: After reset, allocations into an untouched set fill ways 0, 1, 2, 3 in that order.
- R11: If an allocation and a lookup hit fall in the same set in the same cycle, only the allocation changes that set's age ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A fetch lookup is present this cycle |
| lk_pc | input | PC_W | Fetch word address to look up |
| lk_hit | output | 1 | A valid entry matches the lookup address |
| lk_taken | output | 1 | Predicted direction (0 on a miss) |
| lk_target | output | PC_W | Stored target (0 on a miss) |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | Word address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| up_target | input | PC_W | Actual target of the resolved branch |

## Verification
The hardest states to reach from the ports are the replacement corners. Eviction only happens once a set holds four live tags. The lookup-versus-allocation age conflict of R11 only happens when a hitting fetch and a missing taken branch land in the same set on the same edge. Directed sequences fill a set, refresh one way through a lookup and then force an allocation. A dedicated step issues a lookup hit together with an allocation in one set. The random phase then draws addresses from a few sets and a small pool of tags, so sets keep overflowing, lookups and allocations collide often, and the bench model's age ordering is compared indirectly through which entries survive.

// File: rtl/btb_pkg.sv
// Package: shared counter encoding and helper for the branch target buffer.
// Assumes a 2-bit direction counter whose upper bit is the prediction.
package btb_pkg;

    typedef enum logic [1:0] {
        DIR_STRONG_NT = 2'b00,
        DIR_WEAK_NT   = 2'b01,
        DIR_WEAK_T    = 2'b10,
        DIR_STRONG_T  = 2'b11
    } dir_ctr_e;

    // Move a direction counter one step toward the resolved outcome, saturating.
    function automatic logic [1:0] dir_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) begin
            nxt = (cur == DIR_STRONG_T) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == DIR_STRONG_NT) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/btb_tag_match.sv
// Module: compares one probe tag against every way of a selected set.
// Assumes at most one valid way holds a given tag (the buffer never allocates
// a tag that already hits), so the index encoder needs no priority.
module btb_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 26,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        any_hit,
    output logic [WAYS-1:0]             hit_oh,
    output logic [WAY_W-1:0]            hit_idx
);

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_oh[w] = way_vld[w] && (way_tag[w] == probe_tag);
    end

    assign any_hit = |hit_oh;

    // Encode the matching way into an index.
    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_oh[w]) hit_idx = WAY_W'(w);
        end
    end

endmodule

// File: rtl/btb_lru.sv
// Module: exact age ordering of the ways in every set, plus victim choice.
// Age 0 is the most recent and WAYS-1 the least recent. Ages in a set are
// always a permutation. Allocation takes precedence over a lookup touch
// in the same set on the same edge.
module btb_lru #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_set,
    input  logic [WAY_W-1:0] alloc_way,
    input  logic [IDX_W-1:0] victim_set,
    output logic [WAY_W-1:0] victim_way
);

    typedef logic [WAYS-1:0][WAY_W-1:0] age_vec_t;

    age_vec_t age_q [SETS];

    // Return the ordering after the given way becomes the most recent.
    function automatic age_vec_t make_recent(input age_vec_t cur, input logic [WAY_W-1:0] way);
        age_vec_t nxt;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way)       nxt[w] = '0;
            else if (cur[w] < cur[way]) nxt[w] = cur[w] + WAY_W'(1);
            else                        nxt[w] = cur[w];
        end
        return nxt;
    endfunction

    // Pick the oldest way of the set being allocated into.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[victim_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
        end
    end

    // Keep the orderings; reset makes way 0 the oldest so fills go 0,1,2,...
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
                end
            end
        end else begin
            if (alloc_en) begin
                age_q[alloc_set] <= make_recent(age_q[alloc_set], alloc_way);
            end
            if (touch_en && !(alloc_en && (alloc_set == touch_set))) begin
                age_q[touch_set] <= make_recent(age_q[touch_set], touch_way);
            end
        end
    end

endmodule

// File: rtl/btb_assoc.sv
// Module: set-associative branch target buffer, top level.
// The lookup is combinational from flop storage (fetch-stage use). There is
// one resolved-branch update per cycle. Addresses are word addresses: the low
// IDX_W bits pick the set and the rest form the tag. Lookups read the state
// from before the current edge (no bypass of a same-cycle update).
module btb_assoc
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 256,
    parameter int WAYS    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);

    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = PC_W - IDX_W;

    // Entry storage, one row per set.
    logic [WAYS-1:0]            vld_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0][PC_W-1:0]  tgt_q [SETS];
    logic [WAYS-1:0][1:0]       ctr_q [SETS];

    // Address split for both ports.
    logic [IDX_W-1:0] lk_set, up_set;
    logic [TAG_W-1:0] lk_tag, up_tag;

    assign lk_set = lk_pc[IDX_W-1:0];
    assign lk_tag = lk_pc[PC_W-1:IDX_W];
    assign up_set = up_pc[IDX_W-1:0];
    assign up_tag = up_pc[PC_W-1:IDX_W];

    // Match results.
    logic             lk_any, up_any;
    logic [WAYS-1:0]  lk_way_oh, up_way_oh;
    logic [WAY_W-1:0] lk_way, up_way;

    btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .way_vld   (vld_q[lk_set]),
        .way_tag   (tag_q[lk_set]),
        .probe_tag (lk_tag),
        .any_hit   (lk_any),
        .hit_oh    (lk_way_oh),
        .hit_idx   (lk_way)
    );

    btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
        .way_vld   (vld_q[up_set]),
        .way_tag   (tag_q[up_set]),
        .probe_tag (up_tag),
        .any_hit   (up_any),
        .hit_oh    (up_way_oh),
        .hit_idx   (up_way)
    );

    // Lookup response; a miss falls back to not-taken with a zero target.
    logic [1:0] lk_ctr;
    assign lk_ctr    = ctr_q[lk_set][lk_way];
    assign lk_hit    = lk_valid && lk_any;
    assign lk_taken  = lk_hit && lk_ctr[1];
    assign lk_target = lk_hit ? tgt_q[lk_set][lk_way] : '0;

    // Update decisions.
    logic             up_hit, up_alloc;
    logic [WAY_W-1:0] victim;
    assign up_hit   = up_valid && up_any;
    assign up_alloc = up_valid && !up_any && up_taken;

    btb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (lk_hit),
        .touch_set  (lk_set),
        .touch_way  (lk_way),
        .alloc_en   (up_alloc),
        .alloc_set  (up_set),
        .alloc_way  (victim),
        .victim_set (up_set),
        .victim_way (victim)
    );

    // Valid flags: cleared by reset, set by allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (up_alloc) begin
            vld_q[up_set][victim] <= 1'b1;
        end
    end

    // Tag, target and counter fields: written on allocation or update hit.
    always_ff @(posedge clk) begin
        if (up_alloc) begin
            tag_q[up_set][victim] <= up_tag;
            tgt_q[up_set][victim] <= up_target;
            ctr_q[up_set][victim] <= DIR_WEAK_T;
        end else if (up_hit) begin
            tgt_q[up_set][up_way] <= up_target;
            ctr_q[up_set][up_way] <= dir_step(ctr_q[up_set][up_way], up_taken);
        end
    end

endmodule

// File: rtl/btb_assoc_chk.sv
// Module: assertion checker for btb_assoc, attached by bind.
// Relates the lookup and update ports across cycles.
module btb_assoc_chk #(
    parameter int PC_W = 32,
    parameter int WAYS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic            lk_taken,
    input logic [PC_W-1:0] lk_target,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken,
    input logic [PC_W-1:0] up_target,
    input logic [WAYS-1:0] lk_way_oh
);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit); // R1

    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_target == '0)); // R2

    AST_NO_ALLOC_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && lk_valid && lk_pc == up_pc && !lk_hit)
        |=> (!(lk_valid && lk_pc == $past(up_pc)) || !lk_hit)); // R3

    AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && lk_valid && lk_pc == up_pc && !lk_hit)
        |=> (!(lk_valid && lk_pc == $past(up_pc))
             || (lk_hit && lk_taken && lk_target == $past(up_target)))); // R4

    AST_TARGET_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lk_valid && lk_pc == up_pc && lk_hit)
        |=> (!(lk_valid && lk_pc == $past(up_pc))
             || (lk_hit && lk_target == $past(up_target)))); // R6

    AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_way_oh)); // R7

endmodule

bind btb_assoc btb_assoc_chk #(.PC_W(PC_W), .WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_pc     (lk_pc),
    .lk_hit    (lk_hit),
    .lk_taken  (lk_taken),
    .lk_target (lk_target),
    .up_valid  (up_valid),
    .up_pc     (up_pc),
    .up_taken  (up_taken),
    .up_target (up_target),
    .lk_way_oh (lk_way_oh)
);

// File: tb/btb_assoc_tb.sv
`timescale 1ns/1ps
module btb_assoc_tb;

    localparam int PC_W  = 32;
    localparam int ENTRIES = 256;
    localparam int WAYS  = 4;
    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PC_W - IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lk_valid = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_hit, lk_taken;
    logic [PC_W-1:0] lk_target;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    logic [PC_W-1:0] up_target = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    btb_assoc #(.PC_W(PC_W), .ENTRIES(ENTRIES), .WAYS(WAYS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
    );

    // Reference model state, written from the requirements.
    bit              m_vld [SETS][WAYS];
    logic [TAG_W-1:0] m_tag [SETS][WAYS];
    logic [PC_W-1:0] m_tgt [SETS][WAYS];
    logic [1:0]      m_ctr [SETS][WAYS];
    int              m_age [SETS][WAYS];

    function automatic logic [PC_W-1:0] mk(input int tag, input int set);
        return {TAG_W'(tag), IDX_W'(set)};
    endfunction

    function automatic logic [1:0] ctr_next(input logic [1:0] c, input bit t);
        if (t) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    function automatic void m_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 1'b0;
                m_age[s][w] = WAYS - 1 - w;
            end
    endfunction

    function automatic void m_touch(input int s, input int way);
        int old = m_age[s][way];
        for (int w = 0; w < WAYS; w++)
            if (m_age[s][w] < old) m_age[s][w] = m_age[s][w] + 1;
        m_age[s][way] = 0;
    endfunction

    // One cycle: drive at the falling edge, check the combinational result, advance the model.
    task automatic step(input bit lv, input logic [PC_W-1:0] lpc, input bit uv,
                        input logic [PC_W-1:0] upc, input bit ut,
                        input logic [PC_W-1:0] utgt, input string req);
        int ls, us, lw, uw, vic;
        bit lh, uh, alloc, et;
        logic [PC_W-1:0] etg;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_target = utgt;
        #1;
        ls = int'(lpc[IDX_W-1:0]); lh = 1'b0; lw = 0;
        if (lv)
            for (int w = 0; w < WAYS; w++)
                if (m_vld[ls][w] && m_tag[ls][w] == lpc[PC_W-1:IDX_W]) begin lh = 1'b1; lw = w; end
        et  = lh && m_ctr[ls][lw][1];
        etg = lh ? m_tgt[ls][lw] : '0;
        checks++;
        if (lk_hit !== lh || lk_taken !== et || lk_target !== etg) begin
            fails++;
            $display("FAIL %s: pc=%h hit/taken/target got %0b/%0b/%h expected %0b/%0b/%h",
                     req, lpc, lk_hit, lk_taken, lk_target, lh, et, etg);
        end
        us = int'(upc[IDX_W-1:0]); uh = 1'b0; uw = 0;
        if (uv)
            for (int w = 0; w < WAYS; w++)
                if (m_vld[us][w] && m_tag[us][w] == upc[PC_W-1:IDX_W]) begin uh = 1'b1; uw = w; end
        alloc = uv && !uh && ut;
        if (uh) begin
            m_ctr[us][uw] = ctr_next(m_ctr[us][uw], ut);
            m_tgt[us][uw] = utgt;
        end
        if (alloc) begin
            vic = 0;
            for (int w = 0; w < WAYS; w++) if (m_age[us][w] == WAYS - 1) vic = w;
            m_vld[us][vic] = 1'b1; m_tag[us][vic] = upc[PC_W-1:IDX_W];
            m_tgt[us][vic] = utgt; m_ctr[us][vic] = 2'b10;
            m_touch(us, vic);
        end
        if (lh && !(alloc && us == ls)) m_touch(ls, lw);
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string req);
        step(1'b1, pc, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input bit t, input logic [PC_W-1:0] tg, input string req);
        step(1'b0, '0, 1'b1, pc, t, tg, req);
    endtask

    // Directed checks that need an exact value rather than model agreement.
    task automatic expect_hit(input logic [PC_W-1:0] pc, input bit hit, input bit tk,
                              input logic [PC_W-1:0] tg, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; up_valid = 1'b0;
        #1;
        checks++;
        if (lk_hit !== hit || lk_taken !== tk || (hit && lk_target !== tg)) begin
            fails++;
            $display("FAIL %s: pc=%h got %0b/%0b/%h expected %0b/%0b/%h",
                     req, pc, lk_hit, lk_taken, lk_target, hit, tk, tg);
        end
        if (hit) begin
            for (int w = 0; w < WAYS; w++)
                if (m_vld[int'(pc[IDX_W-1:0])][w] && m_tag[int'(pc[IDX_W-1:0])][w] == pc[PC_W-1:IDX_W])
                    m_touch(int'(pc[IDX_W-1:0]), w);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        int seed = 32'h5eed_b7b0;
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, all lookups miss
        for (int i = 0; i < 6; i++) expect_hit(mk(i * 7 + 1, i * 9), 1'b0, 1'b0, '0, "R1");
        // R2: invalid lookup reports default
        step(1'b0, mk(3, 3), 1'b0, '0, 1'b0, '0, "R2");

        // R3: not-taken miss does not allocate
        upd(mk(11, 5), 1'b0, 32'h1000, "R3");
        expect_hit(mk(11, 5), 1'b0, 1'b0, '0, "R3");
        // R4 / R9: same-cycle lookup still misses, next cycle hits
        step(1'b1, mk(11, 5), 1'b1, mk(11, 5), 1'b1, 32'h0000_2000, "R9");
        expect_hit(mk(11, 5), 1'b1, 1'b1, 32'h0000_2000, "R4");

        // R5: counter walk 10 -> 11 -> 10 -> 01 -> 00 -> 00 -> 01 -> 10
        upd(mk(11, 5), 1'b1, 32'h2000, "R5");
        upd(mk(11, 5), 1'b0, 32'h2000, "R5");
        expect_hit(mk(11, 5), 1'b1, 1'b1, 32'h2000, "R5 one wrong outcome keeps taken");
        upd(mk(11, 5), 1'b0, 32'h2000, "R5");
        expect_hit(mk(11, 5), 1'b1, 1'b0, 32'h2000, "R5 two wrong outcomes flip");
        upd(mk(11, 5), 1'b0, 32'h2000, "R5");
        upd(mk(11, 5), 1'b0, 32'h2000, "R5");
        upd(mk(11, 5), 1'b1, 32'h2000, "R5");
        expect_hit(mk(11, 5), 1'b1, 1'b0, 32'h2000, "R5 saturated low");
        upd(mk(11, 5), 1'b1, 32'h2000, "R5");
        expect_hit(mk(11, 5), 1'b1, 1'b1, 32'h2000, "R5");

        // R6: target overwritten on a not-taken hit as well
        upd(mk(11, 5), 1'b0, 32'h0000_3abc, "R6");
        expect_hit(mk(11, 5), 1'b1, 1'b0, 32'h0000_3abc, "R6");

        // R10: fresh set fills ways in order; R7: four coexist
        for (int i = 0; i < 4; i++) upd(mk(40 + i, 20), 1'b1, 32'h100 + i, "R10");
        for (int i = 0; i < 4; i++) expect_hit(mk(40 + i, 20), 1'b1, 1'b1, 32'h100 + i, "R7");
        // R8: last lookups made tag 40 oldest-but-refreshed order 40,41,42,43; refresh 40 again
        expect_hit(mk(40, 20), 1'b1, 1'b1, 32'h100, "R8");
        upd(mk(50, 20), 1'b1, 32'h500, "R8");
        expect_hit(mk(41, 20), 1'b0, 1'b0, '0, "R8 LRU way evicted");
        expect_hit(mk(40, 20), 1'b1, 1'b1, 32'h100, "R8 refreshed way kept");
        expect_hit(mk(50, 20), 1'b1, 1'b1, 32'h500, "R8");

        // R11: lookup hit and allocation in one set on one edge
        upd(mk(60, 33), 1'b1, 32'h600, "R11");
        step(1'b1, mk(60, 33), 1'b1, mk(61, 33), 1'b1, 32'h610, "R11");
        upd(mk(62, 33), 1'b1, 32'h620, "R11");
        upd(mk(63, 33), 1'b1, 32'h630, "R11");
        upd(mk(64, 33), 1'b1, 32'h640, "R11");
        for (int i = 60; i < 65; i++) look(mk(i, 33), "R11");

        // Random phase: few sets, few tags, model comparison (R2..R11)
        void'($urandom(seed));
        for (int i = 0; i < 6000; i++) begin
            step($urandom_range(0, 3) != 0, mk($urandom_range(1, 7), $urandom_range(0, 2)),
                 $urandom_range(0, 2) != 0, mk($urandom_range(1, 7), $urandom_range(0, 2)),
                 $urandom_range(0, 2) != 0, {$urandom_range(0, 65535), 16'h0},
                 "R8/R11 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule